// File: doc/BRIEF.md
# PWM Control Input Qualifier Latch

This block conditions a single control input for a PWM generator, such as a fault or current-limit line. A 5-bit field in a 16-bit control register picks one line of a 32-line source bus. The selected line can be inverted. It can also be resampled so that it only changes on the PWM end-of-cycle strobe. The conditioned source is then gated by an acceptance qualifier, and when both are true an output latch is set.

The qualifier is one of several generator-internal conditions, an alternate source, a software bit or a constant true, and it can be inverted. The latch is released by a selectable termination event. The candidates are a falling edge of the conditioned source, one of three trigger events, an alternate source, or a software write. Depending on one control bit, the release happens at once or waits for the next end-of-cycle strobe. A waiting release is held in a pending flag until the latch clears.

The block is used beside a PWM generator. The generator supplies the end-of-cycle strobe, the qualifier candidates and the trigger events, and it consumes the latched output to drive its override action.

Top module: `pwm_ci_latch`

## Requirements
- R1: A synchronous active-high reset clears the control register to 0x0000, the latch output to 0 and any pending termination.
- R2: Control bits 4:0 select source line n of `src_bus`. Codes 0, 4, 5, 6, 7 and 30 are reserved and read as inactive whatever the line carries.
- R3: Control bit 5 inverts the selected source, so a low line on a valid code becomes active.
- R4: With control bit 6 set, the conditioned source takes the selected value only in a cycle where `eoc` is high. A source change therefore sets the latch two clock edges after the `eoc` cycle, and never before it.
- R5: Control bits 10:8 select the qualifier: 000 constant true, 001 `duty_act`, 010 `leb_act`, 011 `gen_trig`, 100/101/110 `alt_q[0]`/`alt_q[1]`/`alt_q[2]`, 111 `sw_qual`.
- R6: Control bit 11 inverts the chosen qualifier, including the constant-true code.
- R7: In any cycle where the conditioned source and the qualifier are both true, `ci_active` is 1 after the next clock edge. This set wins over a termination in the same cycle.
- R8: Control bits 14:12 select the hardware termination event: 000 none (manual only), 001 a 1-to-0 transition of the conditioned source, 010/011/100 `trig_a`/`trig_b`/`trig_c`, 101/110/111 `alt_t[0]`/`alt_t[1]`/`alt_t[2]`. Non-selected candidates have no effect.
- R9: A register write with bit 7 set produces one termination event in the cycle after the write, whatever the selection. Bit 7 always reads back as 0.
- R10: With control bit 15 set, a termination event clears `ci_active` at the clock edge that ends the event's cycle.
- R11: With control bit 15 clear, a termination event is held pending. `ci_active` clears at the edge ending the next cycle with `eoc` high, which may be the event's own cycle. The pending flag is consumed by that clear.
- R12: A write on `reg_we` loads `reg_wdata` into the control register, visible on `reg_rdata` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_bus | input | 32 | Candidate control input lines |
| duty_act | input | 1 | Duty-cycle-active qualifier candidate |
| leb_act | input | 1 | Leading-edge-blanking-active qualifier candidate |
| gen_trig | input | 1 | Generator-triggered qualifier candidate |
| alt_q | input | 3 | Alternate qualifier sources |
| sw_qual | input | 1 | Software qualifier bit |
| trig_a | input | 1 | Trigger event A |
| trig_b | input | 1 | Trigger event B |
| trig_c | input | 1 | Trigger event C |
| alt_t | input | 3 | Alternate termination sources |
| eoc | input | 1 | PWM end-of-cycle strobe |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| ci_active | output | 1 | Latched active control input |

## Verification
Most wrong internal states reach `ci_active` within one or two clock edges. A wrong selector or polarity shows as a set or a missing set one edge after the stimulus. A stuck resampling register shows two edges after an `eoc` cycle. A lost or stale pending flag shows only at the next `eoc`, so a missing clear or an early clear in deferred mode is detected there. A pending flag that survives a clear only shows when the latch is set again and a later `eoc` clears it without a new event. The bench therefore rearms the latch after each deferred release and drives a further `eoc`.

// File: rtl/pwm_ci_pkg.sv
package pwm_ci_pkg;

    localparam int CFG_W = 16;
    localparam int SRC_N = 32;
    localparam int SEL_W = $clog2(SRC_N);
    localparam int ALT_N = 3;

    typedef struct packed {
        logic             tsd;      // 1: terminate immediately
        logic [2:0]       term;     // termination selector
        logic             aqps;     // qualifier inversion
        logic [2:0]       aqss;     // qualifier selector
        logic             swterm;   // write-one software terminate
        logic             psync;    // resample source on end-of-cycle
        logic             pps;      // source inversion
        logic [SEL_W-1:0] pss;      // source line selector
    } ci_cfg_t;

    typedef enum logic [2:0] {
        Q_FORCE = 3'd0,
        Q_DUTY  = 3'd1,
        Q_LEB   = 3'd2,
        Q_TRIG  = 3'd3,
        Q_ALT0  = 3'd4,
        Q_ALT1  = 3'd5,
        Q_ALT2  = 3'd6,
        Q_SOFT  = 3'd7
    } qual_sel_e;

    typedef enum logic [2:0] {
        T_MANUAL = 3'd0,
        T_AUTO   = 3'd1,
        T_TRIGA  = 3'd2,
        T_TRIGB  = 3'd3,
        T_TRIGC  = 3'd4,
        T_ALT0   = 3'd5,
        T_ALT1   = 3'd6,
        T_ALT2   = 3'd7
    } term_sel_e;

endpackage

// File: rtl/ci_src_cond.sv
module ci_src_cond
    import pwm_ci_pkg::*;
#(
    parameter int          N         = SRC_N,
    parameter logic [N-1:0] RSVD_MASK = '0,
    localparam int         SW        = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_bus,
    input  logic [SW-1:0] sel,
    input  logic          inv,
    input  logic          sync,
    input  logic          eoc,
    output logic          cond,
    output logic          fall
);

    logic raw, pol, src_s, src_d;

    assign raw  = src_bus[sel] & ~RSVD_MASK[sel];
    assign pol  = raw ^ inv;
    assign cond = sync ? src_s : pol;
    assign fall = src_d & ~cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_s <= 1'b0;
            src_d <= 1'b0;
        end else begin
            if (eoc) src_s <= pol;
            src_d <= cond;
        end
    end

    // R4: in resampled mode the source cannot move between end-of-cycle strobes
    p_sync_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sync && !eoc) |=> (!sync || $stable(cond)));

endmodule

// File: rtl/ci_qual_sel.sv
module ci_qual_sel
    import pwm_ci_pkg::*;
(
    input  qual_sel_e        sel,
    input  logic             inv,
    input  logic             duty_act,
    input  logic             leb_act,
    input  logic             gen_trig,
    input  logic [ALT_N-1:0] alt_q,
    input  logic             sw_qual,
    output logic             qual
);

    logic q_raw;

    always_comb begin
        unique case (sel)
            Q_FORCE: q_raw = 1'b1;
            Q_DUTY:  q_raw = duty_act;
            Q_LEB:   q_raw = leb_act;
            Q_TRIG:  q_raw = gen_trig;
            Q_ALT0:  q_raw = alt_q[0];
            Q_ALT1:  q_raw = alt_q[1];
            Q_ALT2:  q_raw = alt_q[2];
            Q_SOFT:  q_raw = sw_qual;
            default: q_raw = 1'b0;
        endcase
    end

    assign qual = q_raw ^ inv;

endmodule

// File: rtl/ci_term_sel.sv
module ci_term_sel
    import pwm_ci_pkg::*;
(
    input  term_sel_e        sel,
    input  logic             fall,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic             trig_c,
    input  logic [ALT_N-1:0] alt_t,
    output logic             evt
);

    always_comb begin
        unique case (sel)
            T_MANUAL: evt = 1'b0;
            T_AUTO:   evt = fall;
            T_TRIGA:  evt = trig_a;
            T_TRIGB:  evt = trig_b;
            T_TRIGC:  evt = trig_c;
            T_ALT0:   evt = alt_t[0];
            T_ALT1:   evt = alt_t[1];
            T_ALT2:   evt = alt_t[2];
            default:  evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_ci_latch.sv
module pwm_ci_latch
    import pwm_ci_pkg::*;
#(
    parameter logic [SRC_N-1:0] RSVD_MASK = 32'h4000_00F1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_bus,
    input  logic             duty_act,
    input  logic             leb_act,
    input  logic             gen_trig,
    input  logic [ALT_N-1:0] alt_q,
    input  logic             sw_qual,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic             trig_c,
    input  logic [ALT_N-1:0] alt_t,
    input  logic             eoc,
    input  logic             reg_we,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    output logic             ci_active
);

    ci_cfg_t cfg;
    logic    sw_term_q;
    logic    cond, fall, qual, hw_evt;
    logic    term_evt, set, clr, pending;

    // control register; the software-terminate bit is not stored
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            sw_term_q <= 1'b0;
        end else begin
            sw_term_q <= reg_we & reg_wdata[7];
            if (reg_we) begin
                cfg        <= ci_cfg_t'(reg_wdata);
                cfg.swterm <= 1'b0;
            end
        end
    end

    assign reg_rdata = cfg;

    ci_src_cond #(
        .N         (SRC_N),
        .RSVD_MASK (RSVD_MASK)
    ) u_src (
        .clk     (clk),
        .rst     (rst),
        .src_bus (src_bus),
        .sel     (cfg.pss),
        .inv     (cfg.pps),
        .sync    (cfg.psync),
        .eoc     (eoc),
        .cond    (cond),
        .fall    (fall)
    );

    ci_qual_sel u_qual (
        .sel      (qual_sel_e'(cfg.aqss)),
        .inv      (cfg.aqps),
        .duty_act (duty_act),
        .leb_act  (leb_act),
        .gen_trig (gen_trig),
        .alt_q    (alt_q),
        .sw_qual  (sw_qual),
        .qual     (qual)
    );

    ci_term_sel u_term (
        .sel    (term_sel_e'(cfg.term)),
        .fall   (fall),
        .trig_a (trig_a),
        .trig_b (trig_b),
        .trig_c (trig_c),
        .alt_t  (alt_t),
        .evt    (hw_evt)
    );

    assign term_evt = hw_evt | sw_term_q;
    assign set      = cond & qual;
    assign clr      = cfg.tsd ? (term_evt | pending)
                              : (eoc & (term_evt | pending));

    always_ff @(posedge clk) begin
        if (rst) begin
            ci_active <= 1'b0;
            pending   <= 1'b0;
        end else begin
            if (set)      ci_active <= 1'b1;
            else if (clr) ci_active <= 1'b0;
            if (clr)           pending <= 1'b0;
            else if (term_evt) pending <= 1'b1;
        end
    end

    // R7: a qualified source always leaves the latch set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> ci_active);

    // R10: immediate release when no set competes
    p_imm_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg.tsd && term_evt && !set) |=> !ci_active);

    // R11: deferred mode never releases outside an end-of-cycle strobe
    p_defer_wait_r11: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tsd && !eoc && ci_active) |=> ci_active);

    // R11: a release consumes the pending termination
    p_pend_drop_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pending);

    // R12: written value appears with the terminate bit dropped
    p_rdata_r12: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata == {$past(reg_wdata[15:8]), 1'b0, $past(reg_wdata[6:0])}));

endmodule

// File: tb/pwm_ci_latch_bench.sv
module pwm_ci_latch_bench;

    localparam int TIMEOUT = 200000;
    localparam int NV      = 22;

    // vector: cfg[31:16] line[15:11] level[10] qin[9:3] pad[2:1] expected[0]
    // qin = {sw_qual, alt_q[2], alt_q[1], alt_q[0], gen_trig, leb_act, duty_act}
    localparam logic [31:0] VEC [NV] = '{
        {16'h0003, 5'd3,  1'b1, 7'b0000000, 2'b00, 1'b1},
        {16'h0003, 5'd3,  1'b0, 7'b0000000, 2'b00, 1'b0},
        {16'h0000, 5'd0,  1'b1, 7'b0000000, 2'b00, 1'b0},
        {16'h0005, 5'd5,  1'b1, 7'b0000000, 2'b00, 1'b0},
        {16'h001E, 5'd30, 1'b1, 7'b0000000, 2'b00, 1'b0},
        {16'h001F, 5'd31, 1'b1, 7'b0000000, 2'b00, 1'b1},
        {16'h0023, 5'd3,  1'b0, 7'b0000000, 2'b00, 1'b1},
        {16'h0023, 5'd3,  1'b1, 7'b0000000, 2'b00, 1'b0},
        {16'h0108, 5'd8,  1'b1, 7'b0000001, 2'b00, 1'b1},
        {16'h0108, 5'd8,  1'b1, 7'b0000000, 2'b00, 1'b0},
        {16'h0208, 5'd8,  1'b1, 7'b0000010, 2'b00, 1'b1},
        {16'h0208, 5'd8,  1'b1, 7'b0000001, 2'b00, 1'b0},
        {16'h0308, 5'd8,  1'b1, 7'b0000100, 2'b00, 1'b1},
        {16'h0408, 5'd8,  1'b1, 7'b0001000, 2'b00, 1'b1},
        {16'h0508, 5'd8,  1'b1, 7'b0010000, 2'b00, 1'b1},
        {16'h0608, 5'd8,  1'b1, 7'b0100000, 2'b00, 1'b1},
        {16'h0608, 5'd8,  1'b1, 7'b0011000, 2'b00, 1'b0},
        {16'h0708, 5'd8,  1'b1, 7'b1000000, 2'b00, 1'b1},
        {16'h0708, 5'd8,  1'b1, 7'b0111111, 2'b00, 1'b0},
        {16'h0908, 5'd8,  1'b1, 7'b0000000, 2'b00, 1'b1},
        {16'h0908, 5'd8,  1'b1, 7'b0000001, 2'b00, 1'b0},
        {16'h0808, 5'd8,  1'b1, 7'b0000000, 2'b00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_bus = '0;
    logic        duty_act = 1'b0, leb_act = 1'b0, gen_trig = 1'b0, sw_qual = 1'b0;
    logic [2:0]  alt_q = '0, alt_t = '0;
    logic        trig_a = 1'b0, trig_b = 1'b0, trig_c = 1'b0;
    logic        eoc = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ci_active;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pwm_ci_latch u_pwm_ci_latch (
        .clk       (clk),
        .rst       (rst),
        .src_bus   (src_bus),
        .duty_act  (duty_act),
        .leb_act   (leb_act),
        .gen_trig  (gen_trig),
        .alt_q     (alt_q),
        .sw_qual   (sw_qual),
        .trig_a    (trig_a),
        .trig_b    (trig_b),
        .trig_c    (trig_c),
        .alt_t     (alt_t),
        .eoc       (eoc),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ci_active (ci_active)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        reg_we    = 1'b1;
        reg_wdata = v;
        step();
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    // one-cycle pulse on source line 3 sets the latch (qualifier code 000)
    task automatic arm();
        src_bus = 32'd1 << 3;
        step();
        src_bus = '0;
    endtask

    task automatic pulse_term(input logic [5:0] tc);
        {alt_t, trig_c, trig_b, trig_a} = tc;
        step();
        {alt_t, trig_c, trig_b, trig_a} = '0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        step();
        rst = 1'b0;

        // R1: reset state, also after a register write
        chk16(reg_rdata, 16'h0000, "R1 rdata after reset");
        chk(ci_active, 1'b0, "R1 latch after reset");
        wr(16'hFFFF);
        do_reset();
        chk16(reg_rdata, 16'h0000, "R1 rdata cleared by reset");

        // R12 and R9: write port and terminate bit read-back
        wr(16'hA5F3);
        chk16(reg_rdata, 16'hA573, "R12 R9 readback");

        // table: source selection, polarity, qualifier codes, set
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(VEC[i][31:16]);
            src_bus = VEC[i][10] ? (32'd1 << VEC[i][15:11]) : 32'd0;
            {sw_qual, alt_q, gen_trig, leb_act, duty_act} = VEC[i][9:3];
            step();
            chk(ci_active, VEC[i][0], $sformatf("R2 R3 R5 R6 R7 vector %0d", i));
            src_bus = '0;
            {sw_qual, alt_q, gen_trig, leb_act, duty_act} = '0;
        end

        // R4: resampled source waits for end-of-cycle
        do_reset();
        wr(16'h8043);
        src_bus = 32'd1 << 3;
        repeat (3) step();
        chk(ci_active, 1'b0, "R4 no set before eoc");
        eoc = 1'b1;
        step();
        eoc = 1'b0;
        chk(ci_active, 1'b0, "R4 one edge after eoc");
        step();
        chk(ci_active, 1'b1, "R4 two edges after eoc");
        src_bus = '0;

        // R10: immediate release on trigger A, set wins when simultaneous
        do_reset();
        wr(16'hA003);
        arm();
        chk(ci_active, 1'b1, "R7 armed");
        pulse_term(6'b000010);
        chk(ci_active, 1'b1, "R8 trig_b ignored under code 010");
        src_bus = 32'd1 << 3;
        trig_a  = 1'b1;
        step();
        src_bus = '0;
        trig_a  = 1'b0;
        chk(ci_active, 1'b1, "R7 set wins over termination");
        pulse_term(6'b000001);
        chk(ci_active, 1'b0, "R10 immediate release");

        // R11: deferred release, pending consumed by the clear
        do_reset();
        wr(16'h2003);
        arm();
        pulse_term(6'b000001);
        chk(ci_active, 1'b1, "R11 held after event");
        step();
        chk(ci_active, 1'b1, "R11 still held without eoc");
        eoc = 1'b1;
        step();
        eoc = 1'b0;
        chk(ci_active, 1'b0, "R11 released at eoc");
        arm();
        eoc = 1'b1;
        step();
        eoc = 1'b0;
        chk(ci_active, 1'b1, "R11 pending consumed");
        trig_a = 1'b1;
        eoc    = 1'b1;
        step();
        trig_a = 1'b0;
        eoc    = 1'b0;
        chk(ci_active, 1'b0, "R11 event and eoc same cycle");

        // R8: auto-terminate on falling conditioned source
        do_reset();
        wr(16'h9003);
        src_bus = 32'd1 << 3;
        step();
        step();
        chk(ci_active, 1'b1, "R8 auto held while source high");
        src_bus = '0;
        step();
        chk(ci_active, 1'b0, "R8 auto release on falling edge");

        // R9: software terminate acts one cycle after the write
        do_reset();
        wr(16'h8003);
        arm();
        wr(16'h8083);
        chk(ci_active, 1'b1, "R9 not yet released");
        chk16(reg_rdata, 16'h8003, "R9 terminate bit reads 0");
        step();
        chk(ci_active, 1'b0, "R9 software release");

        // R8: every hardware termination code, wrong candidates ignored
        for (int c = 0; c < 8; c++) begin
            if (c == 1) continue;
            do_reset();
            wr(16'h8003 | (16'(c) << 12));
            arm();
            if (c == 0) begin
                pulse_term(6'b111111);
                chk(ci_active, 1'b1, "R8 manual ignores hardware");
            end else begin
                pulse_term(~(6'd1 << (c - 2)));
                chk(ci_active, 1'b1, $sformatf("R8 code %0d others ignored", c));
                pulse_term(6'd1 << (c - 2));
                chk(ci_active, 1'b0, $sformatf("R8 code %0d release", c));
            end
        end

        summary();
    end

endmodule